// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets a host processor read and write the management registers of Ethernet PHYs over the two-wire MDC/MDIO serial interface. The host sees four 32-bit registers. A setup register holds the MDC clock divisor and an enable bit. A control register holds the target PHY and register addresses, the operation and a start bit, and it carries a read-only ready flag. The other two are a write-data register and a read-data register.

To write a PHY register, software loads the 16-bit value into the write-data register. It then writes the control register with the start bit set. To read one, software writes the control register with the read operation and the start bit, polls until ready returns to 1, and then fetches the result from the read-data register. On the line side the block drives MDC and drives MDIO through a tri-state split (output value, output enable, input). It shifts out a full frame: 32-bit preamble, start, opcode, addresses, turnaround and 16 data bits.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Each MDC half-period lasts exactly div+1 host clock cycles, so fMDC = fHOST/((div+1)*2). The first low half is counted from the start of the transaction. MDC stays low whenever no transaction runs.
- R2: While the enable bit (setup register bit 31) is 0, MDC does not toggle, ready reads 0 and a start request is discarded. Clearing enable during a transaction abandons it: MDC goes low and MDIO is released within two host cycles.
- R3: Ready (control register bit 31) reads 1 when the block is enabled and idle. It reads 0 from the cycle after a start is accepted until the transaction completes, and then it returns to 1.
- R4: Register offsets: 0 = setup (divisor in bits [DIV_W-1:0], enable in bit 31); 1 = control (PHY address [4:0], register address [12:8], operation bit 16 with 1 = read and 0 = write, start bit 24); 2 = write data [15:0]; 3 = read data [15:0]. Setup reads back as written.
- R5: A write frame, in the order sent, is 32 ones, 01, opcode 01, the PHY address MSB first, the register address MSB first, turnaround 10, and the write-data value MSB first. The master drives all 64 bits.
- R6: A read frame sends opcode 10 and drives MDIO for the first 46 bits only. MDIO is released for the two turnaround bits and the 16 data bits. The data bits are sampled MSB first, and afterwards the read-data register holds them in bits [15:0] with bits [31:16] at zero.
- R7: The MDIO output value changes only on the host cycle in which MDC falls, or when a transaction starts. Read data is captured on the MDC rising edge.
- R8: A control-register write made while a transaction is in progress is ignored entirely: the running frame continues unchanged, no second frame follows, and the stored control fields keep their values.
- R9: The start bit is self-clearing and always reads back 0. Between transactions MDIO is released (output enable 0).
- R10: A host read returns its register value on host_rdata one clock after host_rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Registered read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value sampled from the pad |

## Verification
The assertions assume that the host leaves the divisor unchanged while a transaction runs. They also assume that the host issues no read and write strobe in the same cycle. The stimulus changes the setup register only while ready reads 1, or on purpose to clear enable in the abort scenario. It drives a single strobe per cycle. The bench PHY model changes mdio_i only after MDC falls, so the value is stable at each rising edge where the master samples it.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int REG_AW     = 2;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int DATA_W     = 16;
  localparam int TA_START   = FRAME_LEN - DATA_W - 2;
  localparam int DATA_START = FRAME_LEN - DATA_W;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  localparam logic [REG_AW-1:0] OFS_SETUP = 2'd0;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 2'd1;
  localparam logic [REG_AW-1:0] OFS_WDATA = 2'd2;
  localparam logic [REG_AW-1:0] OFS_RDATA = 2'd3;

  localparam int BIT_EN    = 31;
  localparam int BIT_READY = 31;
  localparam int BIT_START = 24;
  localparam int BIT_OP    = 16;
  localparam int RA_LSB    = 8;

  typedef struct packed {
    logic              rd;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_req_t r);
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    opc = r.rd ? 2'b10 : 2'b01;
    ta  = r.rd ? 2'b11 : 2'b10;
    pay = r.rd ? {DATA_W{1'b1}} : r.wdata;
    return {{PRE_LEN{1'b1}}, 2'b01, opc, r.phy, r.regad, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             at_end;

  assign at_end   = (cnt_q == div);
  assign rise_evt = run && at_end && !mdc_q;
  assign fall_evt = run && at_end && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: MDC held low when not running
  p_mdc_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc_q);
  // R1: no toggle before the half-period count completes
  p_half_period_r1: assert property (@(posedge clk) disable iff (rst)
    run && !at_end |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              launch,
  input  mdio_req_t         req,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rx_data
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     idx_nxt;
  logic                 busy_q, rd_q, oe_q;
  logic [DATA_W-1:0]    rx_q;
  logic                 last;

  assign last    = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign idx_nxt = idx_q + 1'b1;
  assign done    = busy_q && en && fall_evt && last;
  assign done_rd = rd_q;
  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = oe_q;
  assign rx_data = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      rx_q   <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      idx_q  <= '0;
    end else if (launch && !busy_q) begin
      busy_q <= 1'b1;
      sh_q   <= build_frame(req);
      idx_q  <= '0;
      rd_q   <= req.rd;
      oe_q   <= 1'b1;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (rise_evt && rd_q && idx_q >= IDX_W'(DATA_START))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (last) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_nxt;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
          oe_q  <= !(rd_q && idx_nxt >= IDX_W'(TA_START));
        end
      end
    end
  end

  // R8: a running transaction is not disturbed
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q && en && !done |=> busy_q);
  // R9: MDIO released whenever idle
  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !oe_q);
  // R6: turnaround and data of a read are not driven
  p_read_released_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q && rd_q && idx_q >= IDX_W'(TA_START) |-> !oe_q);
  // R7: output value moves only on a falling MDC event or a launch
  p_change_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q && !fall_evt |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_rd,
  input  logic [DATA_W-1:0] rx_data,
  output logic              enable,
  output logic [DIV_W-1:0]  div,
  output logic              launch,
  output mdio_req_t         req
);
  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic [4:0]        phy_q, ra_q;
  logic              op_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic [31:0]       rdata_q;
  logic              ready, wr_ctrl;
  logic [31:0]       rmux;
  wire               unused_wbits = ^host_wdata;

  assign ready     = en_q && !busy;
  assign wr_ctrl   = host_wr_en && (host_addr == OFS_CTRL);
  assign launch    = wr_ctrl && host_wdata[BIT_START] && ready;
  assign enable    = en_q;
  assign div       = div_q;
  assign req.rd    = host_wdata[BIT_OP];
  assign req.phy   = host_wdata[4:0];
  assign req.regad = host_wdata[RA_LSB+4:RA_LSB];
  assign req.wdata = wd_q;
  assign host_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= '0;
      phy_q <= '0;
      ra_q  <= '0;
      op_q  <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (host_wr_en && host_addr == OFS_SETUP) begin
        en_q  <= host_wdata[BIT_EN];
        div_q <= host_wdata[DIV_W-1:0];
      end
      if (wr_ctrl && !busy) begin
        phy_q <= host_wdata[4:0];
        ra_q  <= host_wdata[RA_LSB+4:RA_LSB];
        op_q  <= host_wdata[BIT_OP];
      end
      if (host_wr_en && host_addr == OFS_WDATA)
        wd_q <= host_wdata[DATA_W-1:0];
      if (done && done_rd)
        rd_q <= rx_data;
    end
  end

  always_comb begin
    case (host_addr)
      OFS_SETUP: rmux = 32'(div_q) | (32'(en_q) << BIT_EN);
      OFS_CTRL:  rmux = (32'(ready) << BIT_READY) | (32'(op_q) << BIT_OP) |
                        (32'(ra_q) << RA_LSB) | 32'(phy_q);
      OFS_WDATA: rmux = 32'(wd_q);
      default:   rmux = 32'(rd_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata_q <= '0;
    else if (host_rd_en) rdata_q <= rmux;
  end

  // R3: ready drops once a start is accepted
  p_ready_drops_r3: assert property (@(posedge clk) disable iff (rst)
    launch |=> !ready);
  // R6: completed read lands in the read-data register
  p_rdata_capture_r6: assert property (@(posedge clk) disable iff (rst)
    done && done_rd |=> rd_q == $past(rx_data));
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [1:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              enable, launch, busy, done, done_rd;
  logic              rise_evt, fall_evt;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] rx_data;
  mdio_req_t         req;

  mdio_regfile #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done), .done_rd(done_rd), .rx_data(rx_data),
    .enable(enable), .div(div), .launch(launch), .req(req)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy && enable), .div(div),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .en(enable), .launch(launch), .req(req),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .done_rd(done_rd), .rx_data(rx_data)
  );
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and line monitor
  int          fall_n = 0, rise_n = 0;
  logic [15:0] phy_val = '0;
  logic        cap_o [64];
  logic        cap_oe[64];
  time         t_rise = 0, t_fall = 0;
  int          hi_ns = 0, lo_ns = 0;
  int          r7_viol = 0;
  logic        prev_o = 1'b1, prev_oe = 1'b0, prev_mdc = 1'b0;

  always @(posedge mdc) begin
    if (fall_n < 64) begin
      cap_o[fall_n]  = mdio_o;
      cap_oe[fall_n] = mdio_oe;
    end
    if (fall_n > 0) lo_ns = int'($time - t_fall);
    rise_n++;
    t_rise = $time;
  end

  always @(negedge mdc) begin
    fall_n++;
    t_fall = $time;
    hi_ns  = int'($time - t_rise);
    mdio_i = (fall_n >= 48 && fall_n < 64) ? phy_val[63 - fall_n] : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst && prev_oe && (mdio_o !== prev_o) && !(prev_mdc && !mdc))
      r7_viol++;
    prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc = mdc;
  end

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      host_read(2'd1, v);
      if (v[31]) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction

  task automatic check_frame(input string rq, input bit rd, input logic [63:0] ef);
    int bad_o = 0, bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if ((!rd || i < 46) && cap_o[i] !== ef[63 - i]) bad_o++;
      if (cap_oe[i] !== logic'(!(rd && i >= 46))) bad_oe++;
    end
    check(rq, "frame bit mismatches", bad_o, 0);
    check(rq, "output-enable mismatches", bad_oe, 0);
    check(rq, "MDC falls per frame", fall_n, 64);
  endtask

  task automatic do_xfer(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d, input int div, input string rq);
    logic [31:0] v;
    host_write(2'd0, 32'h8000_0000 | div);
    if (rd) phy_val = d; else host_write(2'd2, {16'h0, d});
    fall_n = 0; rise_n = 0;
    host_write(2'd1, (32'h1 << 24) | (32'(rd) << 16) | (32'(ra) << 8) | 32'(phy));
    host_read(2'd1, v);
    check("R3", "ready during transfer", v[31], 0);
    check("R9", "start bit readback", v[24], 0);
    wait_ready();
    check_frame(rq, rd, exp_frame(rd, phy, ra, d));
    check("R1", "MDC high ns", hi_ns, (div + 1) * 20);
    check("R1", "MDC low ns", lo_ns, (div + 1) * 20);
    check("R9", "mdc idle", mdc, 0);
    check("R9", "mdio released", mdio_oe, 0);
    if (rd) begin
      host_read(2'd3, v);
      check("R6", "read data register", v, {16'h0, d});
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "mdc after reset", mdc, 0);
    check("R9", "oe after reset", mdio_oe, 0);
    host_read(2'd1, v);
    check("R2", "ready while disabled", v[31], 0);
    host_read(2'd3, v);
    check("R10", "read data after reset", v, 0);
  endtask

  task automatic t_disabled_start();
    logic [31:0] v;
    rise_n = 0;
    host_write(2'd1, (32'h1 << 24) | 32'h3);
    repeat (200) @(negedge clk);
    check("R2", "MDC rises while disabled", rise_n, 0);
    check("R2", "oe while disabled", mdio_oe, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    host_write(2'd0, 32'h8000_0003);
    host_read(2'd0, v);
    check("R4", "setup readback", v, 32'h8000_0003);
    host_read(2'd1, v);
    check("R3", "ready after enable", v[31], 1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int snap;
    host_write(2'd0, 32'h8000_0001);
    host_write(2'd2, 32'h0000_5AA5);
    fall_n = 0; rise_n = 0;
    host_write(2'd1, (32'h1 << 24) | (32'd9 << 8) | 32'd4);
    repeat (40) @(negedge clk);
    host_write(2'd1, (32'h1 << 24) | (32'h1 << 16) | (32'd30 << 8) | 32'd7);
    wait_ready();
    check_frame("R8", 1'b0, exp_frame(1'b0, 5'd4, 5'd9, 16'h5AA5));
    snap = rise_n;
    repeat (300) @(negedge clk);
    check("R8", "no second frame", rise_n, snap);
    host_read(2'd1, v);
    check("R8", "control fields kept", v & 32'h0001_1F1F, (32'd9 << 8) | 32'd4);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    host_write(2'd0, 32'h8000_0002);
    host_write(2'd2, 32'h0000_1234);
    host_write(2'd1, (32'h1 << 24) | (32'd1 << 8) | 32'd1);
    repeat (100) @(negedge clk);
    host_write(2'd0, 32'h0000_0002);
    @(negedge clk);
    check("R2", "mdc after abort", mdc, 0);
    check("R2", "oe after abort", mdio_oe, 0);
    host_read(2'd1, v);
    check("R2", "ready after abort", v[31], 0);
    host_write(2'd0, 32'h8000_0002);
    host_read(2'd1, v);
    check("R3", "ready after re-enable", v[31], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled_start();
    t_enable();
    do_xfer(1'b0, 5'h11, 5'h0A, 16'hC3A5, 2, "R5");
    do_xfer(1'b0, 5'h1F, 5'h00, 16'h8001, 0, "R5");
    do_xfer(1'b1, 5'h05, 5'h1E, 16'hB00F, 3, "R6");
    do_xfer(1'b1, 5'h00, 5'h1F, 16'h7FFE, 5, "R6");
    t_busy_ignore();
    t_abort();
    do_xfer(1'b1, 5'h0C, 5'h03, 16'h4C21, 1, "R6");
    check("R7", "MDIO changes off falling edge", r7_viol, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule